// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the write state machine that sits behind the command register of a NOR flash array. It takes program, multi-sector erase, whole-array erase, suspend and resume requests that an outer bus decoder has already recognised. It then runs the internal phases on a behavioural cell array: preprogramming of cells that are not yet zero, timed erase pulses with a verify walk, and timed program pulses with a verify step.

The host learns of completion in three ways that are all valid at once: a ready/busy pin, a data-polling bit and a toggle bit in the word returned by a read. A hardware reset aborts whatever is running. A write-protect pin shields the boot sectors, and a low-supply inhibit input makes the block ignore every write request. A parameter chooses whether the eight small boot sectors sit at the top or the bottom of the sector index range. An erase can be paused so that the host can read or program sectors outside the erase set.

Top module: `flash_seq`

## Requirements
- R1: While `rst_n` is low, `rdy` is 1, any running operation is abandoned and `rd_data` clears to 0. After release the block is in read mode. Cells outside an interrupted operation keep their contents.
- R2: A program request (`cmd_op`=1) at `cmd_addr` = {sector[6:0], word[1:0]} only clears bits, so the new word is old AND data. It runs a timed pulse of `PGM_CYC` cycles and a verify cycle, then returns to read mode by itself.
- R3: Before the erase pulse, an erase preprograms to zero every word of the selected sectors that is not already zero. Each such word adds exactly `PGM_CYC` cycles to the busy time.
- R4: An erase (`cmd_op`=2) sets every word of each sector whose bit is set in `erase_sel` to all ones and leaves unselected sectors unchanged. A whole-array erase (`cmd_op`=3) selects every sector.
- R5: `rdy` is 0 from the cycle after a request is accepted until that operation completes or is suspended.
- R6: A read made while busy returns status rather than array data. Status bit 7 is the complement of bit 7 of the program data, or 0 during an erase, and bits 5..0 are 0. Once ready, reads return array data.
- R7: Status bit 6 inverts on every status read.
- R8: Suspend (`cmd_op`=4) during an erase makes `rdy` 1 on the next cycle. Reads of sectors outside the erase set then return array data, and programs to them are carried out. Resume (`cmd_op`=5) continues the erase to completion.
- R9: When `wp_n` is 0, the boot sectors (indices 63..70 with `TOP_BOOT`=1, 0..7 otherwise) are refused. A refused program is busy for exactly one cycle and leaves the array unchanged. An erase skips the refused sectors, and an erase that selects only refused sectors is busy for one cycle.
- R10: While `lv_inh` is 1, every request is ignored: `rdy` stays 1 and the array is unchanged.
- R11: While busy, every request other than suspend is ignored.
- R12: `rd_data` presents the word for `rd_addr` on the cycle after `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_valid | input | 1 | Request strobe |
| cmd_op | input | 3 | Request code: 1 program, 2 sector erase, 3 whole-array erase, 4 suspend, 5 resume |
| cmd_addr | input | 9 | Program address {sector, word} |
| cmd_data | input | 8 | Program data |
| erase_sel | input | 71 | One bit per sector selected for erase |
| wp_n | input | 1 | Low refuses boot sectors |
| lv_inh | input | 1 | High ignores all requests |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Read address {sector, word} |
| rd_data | output | 8 | Array data or status word |
| rdy | output | 1 | High when ready, low when busy |

## Verification
The hardest state to reach from the ports is a suspended erase with a nested program running in another sector. The erase must be stopped mid-preprogram, and the later resume must still finish the interrupted word. The bench gets there by choosing an erase target whose four words are all ones, so that preprogramming is guaranteed to last several pulses. It sends suspend a few cycles after the erase starts, then programs and reads a neighbouring sector before it resumes. The preprogram requirement is checked by timing the same erase twice, once over all-ones cells and once over all-zero cells, and comparing the two busy lengths.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_CHIP   = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        P_IDLE, P_PULSE, P_VERIFY, P_REFUSE
    } pst_e;

    typedef enum logic [2:0] {
        E_IDLE, E_PRE, E_PPULSE, E_PULSE, E_VERIFY, E_REFUSE
    } est_e;
endpackage

// File: rtl/flash_sect_map.sv
module flash_sect_map #(
    parameter int NUM_SECT  = 71,
    parameter int BOOT_SECT = 8,
    parameter bit TOP_BOOT  = 1'b1
) (
    output logic [NUM_SECT-1:0] boot_vec
);
    localparam int BOOT_LO = TOP_BOOT ? NUM_SECT - BOOT_SECT : 0;
    localparam int BOOT_HI = TOP_BOOT ? NUM_SECT - 1 : BOOT_SECT - 1;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        if (g >= BOOT_LO && g <= BOOT_HI) begin : g_boot
            assign boot_vec[g] = 1'b1;
        end else begin : g_main
            assign boot_vec[g] = 1'b0;
        end
    end
endmodule

// File: rtl/flash_rd_fmt.sv
module flash_rd_fmt #(
    parameter int DW = 8
) (
    input  logic          show_stat,
    input  logic          poll,
    input  logic          tog,
    input  logic [DW-1:0] arr,
    output logic [DW-1:0] q
);
    always_comb begin
        if (show_stat) q = {poll, tog, {(DW-2){1'b0}}};
        else           q = arr;
    end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int NUM_SECT  = 71,
    parameter int BOOT_SECT = 8,
    parameter bit TOP_BOOT  = 1'b1,
    parameter int WORD_BITS = 2,
    parameter int DW        = 8,
    parameter int PGM_CYC   = 4,
    parameter int ERS_CYC   = 16,
    localparam int SECT_BITS = $clog2(NUM_SECT),
    localparam int AW        = SECT_BITS + WORD_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [AW-1:0]       cmd_addr,
    input  logic [DW-1:0]       cmd_data,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic                wp_n,
    input  logic                lv_inh,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    output logic                rdy
);
    localparam int NW   = NUM_SECT << WORD_BITS;
    localparam int CMAX = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        pst_e                pst;
        logic [AW-1:0]       paddr;
        logic [DW-1:0]       pdata;
        logic [CW-1:0]       pcnt;
        est_e                est;
        logic [NUM_SECT-1:0] emask;
        logic [AW-1:0]       eptr;
        logic [CW-1:0]       ecnt;
        logic                esusp;
        logic                tog;
        logic [DW-1:0]       rdat;
    } st_t;

    st_t           s_d, s_q;
    logic [DW-1:0] mem_d [NW];
    logic [DW-1:0] mem_q [NW];

    logic [NUM_SECT-1:0]  boot_vec, prot_vec, new_mask;
    logic [SECT_BITS-1:0] cmd_sect, rd_sect, e_sect;
    logic                 cmd_in, rd_in, cmd_prot;
    logic                 erase_act, esusp_q, pidle_q, busy;
    logic                 show_stat, poll;
    logic [DW-1:0]        arr_word, fmt_word;
    op_e                  op;

    flash_sect_map #(.NUM_SECT(NUM_SECT), .BOOT_SECT(BOOT_SECT), .TOP_BOOT(TOP_BOOT))
        u_map (.boot_vec(boot_vec));

    assign prot_vec  = boot_vec & {NUM_SECT{~wp_n}};
    assign cmd_sect  = cmd_addr[AW-1:WORD_BITS];
    assign rd_sect   = rd_addr[AW-1:WORD_BITS];
    assign e_sect    = s_q.eptr[AW-1:WORD_BITS];
    assign cmd_in    = {1'b0, cmd_sect} < (SECT_BITS+1)'(NUM_SECT);
    assign rd_in     = {1'b0, rd_sect} < (SECT_BITS+1)'(NUM_SECT);
    assign cmd_prot  = !cmd_in || prot_vec[cmd_sect];
    assign erase_act = (s_q.est != E_IDLE) && (s_q.est != E_REFUSE);
    assign esusp_q   = s_q.esusp;
    assign pidle_q   = (s_q.pst == P_IDLE);
    assign busy      = !pidle_q || ((s_q.est != E_IDLE) && !esusp_q);
    assign op        = op_e'(cmd_op);

    assign show_stat = busy || (esusp_q && pidle_q && rd_in && s_q.emask[rd_sect]);
    assign poll      = pidle_q ? 1'b0 : ~s_q.pdata[DW-1];
    assign arr_word  = rd_in ? mem_q[rd_addr] : '1;

    flash_rd_fmt #(.DW(DW)) u_fmt (
        .show_stat(show_stat), .poll(poll), .tog(s_q.tog),
        .arr(arr_word), .q(fmt_word)
    );

    always_comb begin
        s_d   = s_q;
        mem_d = mem_q;
        new_mask = ((op == OP_CHIP) ? '1 : erase_sel) & ~prot_vec;

        // read path
        if (rd_en) begin
            s_d.rdat = fmt_word;
            if (show_stat) s_d.tog = ~s_q.tog;
        end

        // program engine
        case (s_q.pst)
            P_PULSE: begin
                if (s_q.pcnt == '0) begin
                    mem_d[s_q.paddr] = mem_q[s_q.paddr] & s_q.pdata;
                    s_d.pst = P_VERIFY;
                end else begin
                    s_d.pcnt = s_q.pcnt - 1'b1;
                end
            end
            P_VERIFY: begin
                if ((mem_q[s_q.paddr] & s_q.pdata) == mem_q[s_q.paddr]) begin
                    s_d.pst = P_IDLE;
                end else begin
                    s_d.pst  = P_PULSE;
                    s_d.pcnt = CW'(PGM_CYC - 1);
                end
            end
            P_REFUSE: s_d.pst = P_IDLE;
            default: ;
        endcase

        // erase engine, frozen while suspended
        if (!esusp_q) begin
            case (s_q.est)
                E_PRE: begin
                    if (s_q.emask[e_sect] && mem_q[s_q.eptr] != '0) begin
                        s_d.est  = E_PPULSE;
                        s_d.ecnt = CW'(PGM_CYC - 1);
                    end else if (s_q.eptr == AW'(NW - 1)) begin
                        s_d.est  = E_PULSE;
                        s_d.ecnt = CW'(ERS_CYC - 1);
                    end else begin
                        s_d.eptr = s_q.eptr + 1'b1;
                    end
                end
                E_PPULSE: begin
                    if (s_q.ecnt == '0) begin
                        mem_d[s_q.eptr] = '0;
                        if (s_q.eptr == AW'(NW - 1)) begin
                            s_d.est  = E_PULSE;
                            s_d.ecnt = CW'(ERS_CYC - 1);
                        end else begin
                            s_d.est  = E_PRE;
                            s_d.eptr = s_q.eptr + 1'b1;
                        end
                    end else begin
                        s_d.ecnt = s_q.ecnt - 1'b1;
                    end
                end
                E_PULSE: begin
                    if (s_q.ecnt == '0) begin
                        for (int i = 0; i < NW; i++) begin
                            if (s_q.emask[i >> WORD_BITS]) mem_d[i] = '1;
                        end
                        s_d.est  = E_VERIFY;
                        s_d.eptr = '0;
                    end else begin
                        s_d.ecnt = s_q.ecnt - 1'b1;
                    end
                end
                E_VERIFY: begin
                    if (s_q.emask[e_sect] && mem_q[s_q.eptr] != '1) begin
                        s_d.est  = E_PULSE;
                        s_d.ecnt = CW'(ERS_CYC - 1);
                    end else if (s_q.eptr == AW'(NW - 1)) begin
                        s_d.est   = E_IDLE;
                        s_d.emask = '0;
                    end else begin
                        s_d.eptr = s_q.eptr + 1'b1;
                    end
                end
                E_REFUSE: s_d.est = E_IDLE;
                default: ;
            endcase
        end

        // request intake
        if (cmd_valid && !lv_inh) begin
            case (op)
                OP_PROG: if (!busy && (s_q.est == E_IDLE || esusp_q)) begin
                    s_d.paddr = cmd_addr;
                    s_d.pdata = cmd_data;
                    if (cmd_prot || (esusp_q && s_q.emask[cmd_sect])) begin
                        s_d.pst = P_REFUSE;
                    end else begin
                        s_d.pst  = P_PULSE;
                        s_d.pcnt = CW'(PGM_CYC - 1);
                    end
                end
                OP_ERASE, OP_CHIP: if (!busy && s_q.est == E_IDLE) begin
                    s_d.emask = new_mask;
                    s_d.eptr  = '0;
                    s_d.est   = (new_mask == '0) ? E_REFUSE : E_PRE;
                end
                OP_SUSP: if (erase_act && !esusp_q && pidle_q) s_d.esusp = 1'b1;
                OP_RESUME: if (esusp_q && pidle_q) s_d.esusp = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = s_q.rdat;
    assign rdy     = ~busy;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rdy,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       lv_inh,
    input logic       rd_en,
    input logic       rd_tog,
    input logic       cmd_prot,
    input logic       erase_act,
    input logic       esusp,
    input logic       pidle
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            rdy_in_reset_chk: assert (rdy);
        end
    end

    // R10
    lv_inh_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && lv_inh && rdy) |=> rdy);

    // R9
    prot_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !lv_inh && rdy && cmd_op == 3'd1 && cmd_prot) |=> !rdy ##1 rdy);

    // R7
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rdy) ##1 (rd_en && !rdy) |=> (rd_tog != $past(rd_tog)));

    // R8
    suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !lv_inh && cmd_op == 3'd4 && erase_act && !esusp && pidle) |=> rdy);

    // R5
    ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> (pidle && (!erase_act || esusp)));
endmodule

bind flash_seq flash_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .lv_inh(lv_inh), .rd_en(rd_en), .rd_tog(rd_data[DW-2]), .cmd_prot(cmd_prot),
    .erase_act(erase_act), .esusp(esusp_q), .pidle(pidle_q)
);

// File: tb/flash_seq_bench.sv
`timescale 1ns/1ps
module flash_seq_bench;
    localparam int NS = 71;
    localparam int AW = 9;
    localparam int PGM_CYC = 4;
    localparam int LIMIT = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic [NS-1:0] erase_sel = '0;
    logic          wp_n = 1'b1;
    logic          lv_inh = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          rdy;

    int errors = 0;
    int checks = 0;

    flash_seq u_flash_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .erase_sel(erase_sel),
        .wp_n(wp_n), .lv_inh(lv_inh), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rdy(rdy)
    );

    always #2.5 clk = ~clk;

    // {wp_n, sector[6:0], word[1:0], data[7:0], expected[7:0]}
    localparam logic [25:0] VEC [8] = '{
        {1'b1, 7'd0,  2'd0, 8'hA5, 8'hA5},
        {1'b1, 7'd0,  2'd0, 8'h0F, 8'h05},
        {1'b1, 7'd10, 2'd3, 8'h3C, 8'h3C},
        {1'b0, 7'd70, 2'd1, 8'h00, 8'hFF},
        {1'b1, 7'd70, 2'd1, 8'h81, 8'h81},
        {1'b0, 7'd1,  2'd2, 8'h77, 8'h77},
        {1'b0, 7'd63, 2'd0, 8'h12, 8'hFF},
        {1'b1, 7'd62, 2'd3, 8'hFE, 8'hFE}
    };

    function automatic logic [AW-1:0] ad(int s, int w);
        return {7'(s), 2'(w)};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [7:0] d, input logic [NS-1:0] sel);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; erase_sel = sel;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        while (!rdy && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (!rdy) begin
            errors++;
            $display("FAIL R5: ready never returned, actual 0 expected 1");
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic prog(input int s, input int w, input logic [7:0] d);
        int c;
        issue(3'd1, ad(s, w), d, '0);
        wait_ready(c);
    endtask

    task automatic erase(input logic [NS-1:0] sel, output int c);
        issue(3'd2, '0, '0, sel);
        wait_ready(c);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d, d2;
        logic [NS-1:0] sel;
        int c, c1, c2;

        repeat (3) @(negedge clk);
        check(rdy, 1, "R1 ready in reset");
        check(rd_data, 0, "R1 rd_data cleared");
        rst_n = 1'b1;
        @(negedge clk);

        // whole-array erase from power-up state
        issue(3'd3, '0, '0, '0);
        check(rdy, 0, "R5 busy after chip erase");
        wait_ready(c);
        rd(ad(0, 0), d);   check(d, 8'hFF, "R4 chip erase s0");
        rd(ad(70, 3), d);  check(d, 8'hFF, "R4 chip erase s70");

        // vector table of programs
        foreach (VEC[i]) begin
            wp_n = VEC[i][25];
            prog(int'(VEC[i][24:18]), int'(VEC[i][17:16]), VEC[i][15:8]);
            rd(ad(int'(VEC[i][24:18]), int'(VEC[i][17:16])), d);
            check(d, VEC[i][7:0], "R2/R9/R12 program vector");
        end
        wp_n = 1'b1;

        // data polling and toggle while busy
        issue(3'd1, ad(20, 0), 8'h5A, '0);
        rd(ad(20, 0), d);
        rd(ad(20, 0), d2);
        check(d[7], 1'b1, "R6 polling bit complement");
        check(d[5:0], 6'd0, "R6 status low bits");
        check(d[6] ^ d2[6], 1'b1, "R7 toggle inverts");
        wait_ready(c);
        rd(ad(20, 0), d);  check(d, 8'h5A, "R6 true data after done");

        // request while busy is ignored
        issue(3'd1, ad(21, 0), 8'h11, '0);
        issue(3'd1, ad(22, 0), 8'h22, '0);
        wait_ready(c);
        rd(ad(22, 0), d);  check(d, 8'hFF, "R11 busy request ignored");
        rd(ad(21, 0), d);  check(d, 8'h11, "R2 first program done");

        // low-supply inhibit
        lv_inh = 1'b1;
        issue(3'd1, ad(23, 0), 8'h00, '0);
        check(rdy, 1, "R10 rdy stays high");
        lv_inh = 1'b0;
        rd(ad(23, 0), d);  check(d, 8'hFF, "R10 array unchanged");

        // preprogram timing
        sel = '0; sel[30] = 1'b1;
        erase(sel, c1);
        for (int w = 0; w < 4; w++) prog(30, w, 8'h00);
        erase(sel, c2);
        check(c1 - c2, 4 * PGM_CYC, "R3 preprogram adds pulses");
        rd(ad(30, 2), d);  check(d, 8'hFF, "R4 sector erased");

        // multi-sector erase
        prog(40, 0, 8'h00); prog(41, 1, 8'h00); prog(42, 2, 8'h00);
        sel = '0; sel[40] = 1'b1; sel[42] = 1'b1;
        erase(sel, c);
        rd(ad(40, 0), d);  check(d, 8'hFF, "R4 selected s40");
        rd(ad(41, 1), d);  check(d, 8'h00, "R4 unselected s41");
        rd(ad(42, 2), d);  check(d, 8'hFF, "R4 selected s42");

        // write protect on erase
        prog(64, 0, 8'h55); prog(50, 0, 8'h55);
        wp_n = 1'b0;
        sel = '0; sel[50] = 1'b1; sel[64] = 1'b1;
        erase(sel, c);
        rd(ad(50, 0), d);  check(d, 8'hFF, "R9 unprotected erased");
        rd(ad(64, 0), d);  check(d, 8'h55, "R9 boot kept");
        sel = '0; sel[65] = 1'b1;
        issue(3'd2, '0, '0, sel);
        check(rdy, 0, "R9 refused erase busy one cycle");
        @(negedge clk);
        check(rdy, 1, "R9 refused erase ends");
        wp_n = 1'b1;

        // suspend and resume
        prog(45, 0, 8'h66);
        sel = '0; sel[44] = 1'b1;
        issue(3'd2, '0, '0, sel);
        repeat (3) @(negedge clk);
        issue(3'd4, '0, '0, '0);
        check(rdy, 1, "R8 ready after suspend");
        rd(ad(45, 0), d);  check(d, 8'h66, "R8 read outside erase set");
        prog(46, 1, 8'h99);
        rd(ad(46, 1), d);  check(d, 8'h99, "R8 program while suspended");
        issue(3'd5, '0, '0, '0);
        check(rdy, 0, "R8 busy after resume");
        wait_ready(c);
        rd(ad(44, 0), d);  check(d, 8'hFF, "R8 erase finished");
        rd(ad(46, 1), d);  check(d, 8'h99, "R8 nested program kept");

        // reset abort
        prog(56, 0, 8'h3C);
        sel = '0; sel[55] = 1'b1;
        issue(3'd2, '0, '0, sel);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(rdy, 1, "R1 abort forces ready");
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy, 1, "R1 read mode after reset");
        rd(ad(56, 0), d);  check(d, 8'h3C, "R1 other cells kept");
        prog(57, 0, 8'hC3);
        rd(ad(57, 0), d);  check(d, 8'hC3, "R1 new program accepted");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule